// File: doc/BRIEF.md
# Nine-Bit Command/Data Serial Writer

This block is a transmit-only serial master for display controllers whose link words are nine bits long. The ninth, most significant bit of each word tells the controller whether the remaining byte is a register address (command) or a parameter byte (data). The host side presents one request holding an 8-bit register address, a parameter count of zero, one or two bytes, and a 16-bit parameter value. The block then sends the whole transfer as back-to-back nine-bit words inside a single chip-select window.

The serial clock idles high. Output data changes while the clock is low and is stable across every rising edge, where the controller samples it. The clock half-period is a parameter counted in system clock cycles. A busy flag covers the whole transfer, including a closing idle gap, and a one-cycle done pulse marks its end. Requests that arrive while busy are dropped.

Top module: `dc9_spi_writer`

## Requirements
- R1: After reset, cs_n_o, sclk_o and mosi_o are 1, and busy_o and done_o are 0.
- R2: sclk_o is 1 whenever cs_n_o is 1. While cs_n_o is 0, mosi_o changes only when sclk_o is low, so it is stable at every rising edge of sclk_o.
- R3: The first word of every transfer is a command word: flag bit 8 = 0, then addr_i[7:0]. Each word is sent most significant bit first, over nine rising edges of sclk_o.
- R4: Every word after the first is a data word: flag bit 8 = 1, then one parameter byte, most significant bit first.
- R5: nparm_i = 0, 1 or 2 gives 1, 2 or 3 words. The value 3 is handled as 2.
- R6: With two parameter bytes, value_i[15:8] goes in the first data word and value_i[7:0] in the second. With one byte, value_i[7:0] is sent.
- R7: cs_n_o falls exactly once per transfer and stays low until the last bit of the last word has been clocked.
- R8: With H = HALF_CYC and W words, busy_o is 1 from the cycle after the request is accepted until done_o rises. done_o is high for exactly one cycle, (3 + 18*W)*H cycles after acceptance, and busy_o is 0 in that cycle.
- R9: A request made while busy_o is 1 is ignored. The transfer in flight keeps its bits and its timing.
- R10: After the last bit, cs_n_o stays high for a 2*H cycle gap before done_o. A request presented during the done cycle is accepted, so cs_n_o is then high for exactly 2*H+1 cycles between the two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request, taken when idle |
| addr_i | input | 8 | Register address for the command word |
| nparm_i | input | 2 | Number of parameter bytes (0..2, 3 acts as 2) |
| value_i | input | 16 | Parameter value |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Every pin is a register output. busy_o is therefore visible one cycle after the accepting edge, and done_o is visible (3 + 18*W)*H cycles after it. The bench counts clock edges from the accepting edge, samples at the falling clock edge, and compares the count with that formula for each transfer length. Serial bits are captured on each rising edge of sclk_o while the chip select is low. At done_o, the bench compares the most recent 9*W captured bits, and the number of bits gathered, against words it builds itself from the request. The cycles of chip-select high time between two transfers issued back to back are counted and compared with 2*H+1.

// File: rtl/dc9_pkg.sv
package dc9_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_GAP   = 3'd4
    } dc9_state_e;
endpackage

// File: rtl/dc9_word_fmt.sv
module dc9_word_fmt #(
    parameter int ADDR_W = 8
) (
    input  logic [1:0]          widx_i,
    input  logic                two_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [2*ADDR_W-1:0] val_i,
    output logic [ADDR_W:0]     word_o
);
    // word 0 carries the address with flag 0; later words carry bytes with flag 1
    always_comb begin
        if (widx_i == 2'd0)
            word_o = {1'b0, addr_i};
        else if (widx_i == 2'd1 && two_i)
            word_o = {1'b1, val_i[2*ADDR_W-1:ADDR_W]};
        else
            word_o = {1'b1, val_i[ADDR_W-1:0]};
    end
endmodule

// File: rtl/dc9_phase_limit.sv
module dc9_phase_limit
    import dc9_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int CNT_W    = 3
) (
    input  dc9_state_e       st_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(2 * HALF_CYC - 1);

    always_comb begin
        if (st_i == ST_GAP)
            last_o = (cnt_i == GAP_END);
        else
            last_o = (cnt_i == HALF_END);
    end
endmodule

// File: rtl/dc9_spi_writer.sv
module dc9_spi_writer
    import dc9_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [1:0]          nparm_i,
    input  logic [2*ADDR_W-1:0] value_i,
    output logic                sclk_o,
    output logic                mosi_o,
    output logic                cs_n_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int DATA_W = 2 * ADDR_W;
    localparam int WORD_W = ADDR_W + 1;
    localparam int CNT_W  = (2 * HALF_CYC > 1) ? $clog2(2 * HALF_CYC) : 1;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

    typedef struct packed {
        dc9_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        widx;
        logic [1:0]        last_w;
        logic [BIT_W-1:0]  bidx;
        logic              two;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] val;
        logic              sclk;
        logic              cs_n;
        logic              mosi;
        logic              done;
    } dc9_regs_t;

    dc9_regs_t r_q, r_d;
    logic [ADDR_W:0]  word_cur;
    logic             phase_last;
    logic [1:0]       np_eff;
    logic [BIT_W-1:0] bidx_m1;

    dc9_word_fmt #(.ADDR_W(ADDR_W)) u_fmt (
        .widx_i (r_q.widx),
        .two_i  (r_q.two),
        .addr_i (r_q.addr),
        .val_i  (r_q.val),
        .word_o (word_cur)
    );

    dc9_phase_limit #(.HALF_CYC(HALF_CYC), .CNT_W(CNT_W)) u_lim (
        .st_i   (r_q.st),
        .cnt_i  (r_q.cnt),
        .last_o (phase_last)
    );

    assign np_eff  = (nparm_i == 2'd3) ? 2'd2 : nparm_i;
    assign bidx_m1 = r_q.bidx - BIT_W'(1);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.cnt  = phase_last ? '0 : r_q.cnt + CNT_W'(1);
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.cnt = '0;
                if (req_i) begin
                    r_d.st     = ST_SETUP;
                    r_d.addr   = addr_i;
                    r_d.val    = value_i;
                    r_d.last_w = np_eff;
                    r_d.two    = (np_eff == 2'd2);
                    r_d.widx   = 2'd0;
                    r_d.bidx   = TOP_BIT;
                    r_d.cs_n   = 1'b0;
                    r_d.mosi   = 1'b0;   // command flag leads
                    r_d.sclk   = 1'b1;
                end
            end
            ST_SETUP: begin
                if (phase_last) begin
                    r_d.st   = ST_LOW;
                    r_d.sclk = 1'b0;
                end
            end
            ST_LOW: begin
                if (phase_last) begin
                    r_d.st   = ST_HIGH;
                    r_d.sclk = 1'b1;
                end
            end
            ST_HIGH: begin
                if (phase_last) begin
                    if (r_q.bidx == '0) begin
                        if (r_q.widx == r_q.last_w) begin
                            r_d.st   = ST_GAP;
                            r_d.cs_n = 1'b1;
                            r_d.mosi = 1'b1;
                        end else begin
                            r_d.st   = ST_LOW;
                            r_d.sclk = 1'b0;
                            r_d.widx = r_q.widx + 2'd1;
                            r_d.bidx = TOP_BIT;
                            r_d.mosi = 1'b1;   // data flag of next word
                        end
                    end else begin
                        r_d.st   = ST_LOW;
                        r_d.sclk = 1'b0;
                        r_d.bidx = bidx_m1;
                        r_d.mosi = word_cur[bidx_m1];
                    end
                end
            end
            ST_GAP: begin
                if (phase_last) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.sclk <= 1'b1;
            r_q.cs_n <= 1'b1;
            r_q.mosi <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk_o = r_q.sclk;
    assign mosi_o = r_q.mosi;
    assign cs_n_o = r_q.cs_n;
    assign busy_o = (r_q.st != ST_IDLE);
    assign done_o = r_q.done;

    // R2: clock parked high outside a transfer
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

    // R2: data held while clock stays high inside a transfer
    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && sclk_o && $past(sclk_o) && !$past(cs_n_o)) |-> $stable(mosi_o));

    // R7: chip select releases only with clock high
    assert_cs_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> sclk_o);

    // R8: done is a single-cycle pulse outside busy
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9: captured request held while busy
    assert_req_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i) |=> ($stable(r_q.addr) && $stable(r_q.val) && $stable(r_q.last_w)));
endmodule

// File: tb/sim_dc9_spi_writer.sv
module sim_dc9_spi_writer;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [1:0]  nparm_i = '0;
    logic [15:0] value_i = '0;
    logic sclk_o, mosi_o, cs_n_o, busy_o, done_o;

    int errors = 0;
    int checks = 0;

    logic [26:0] cap = '0;
    int nbits = 0;
    int cs_falls = 0;
    int hi_run = 0;
    int last_gap = 0;
    bit seen_tx = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dc9_spi_writer #(.HALF_CYC(HALF), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
        .nparm_i(nparm_i), .value_i(value_i), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .cs_n_o(cs_n_o), .busy_o(busy_o), .done_o(done_o)
    );

    always @(posedge sclk_o) begin
        if (cs_n_o === 1'b0) begin
            cap   <= {cap[25:0], mosi_o};
            nbits <= nbits + 1;
        end
    end

    always @(negedge cs_n_o) cs_falls <= cs_falls + 1;

    always @(negedge clk) begin
        if (cs_n_o === 1'b1) hi_run <= hi_run + 1;
        else if (cs_n_o === 1'b0) begin
            if (hi_run > 0 && seen_tx) last_gap <= hi_run;
            hi_run  <= 0;
            seen_tx <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [26:0] exp_bits(input logic [7:0] a, input int np,
                                             input logic [15:0] v);
        if (np == 0) return {18'd0, 1'b0, a};
        if (np == 1) return {9'd0, 1'b0, a, 1'b1, v[7:0]};
        return {1'b0, a, 1'b1, v[15:8], 1'b1, v[7:0]};
    endfunction

    // caller is at a falling clock edge
    task automatic run_tx(input logic [7:0] a, input logic [1:0] np,
                          input logic [15:0] v, input bit interfere);
        int npe, words, n, bits0, falls0, expn, mask;
        logic [26:0] e;
        npe    = (np == 2'd3) ? 2 : int'(np);
        words  = npe + 1;
        expn   = (3 + 18 * words) * HALF + 1;
        bits0  = nbits;
        falls0 = cs_falls;
        req_i = 1'b1; addr_i = a; nparm_i = np; value_i = v;
        @(posedge clk); n = 1;
        @(negedge clk);
        req_i = 1'b0;
        chk(busy_o === 1'b1, "R8", "busy after accept", int'(busy_o), 1);
        while (done_o !== 1'b1 && n < 2000) begin
            if (interfere && n == 6) begin
                req_i = 1'b1; addr_i = ~a; nparm_i = 2'd0; value_i = ~v;
            end else begin
                req_i = 1'b0;
            end
            @(posedge clk); n++;
            @(negedge clk);
        end
        req_i = 1'b0;
        chk(n == expn, interfere ? "R9" : "R8", "done cycle", n, expn);
        chk(busy_o === 1'b0, "R8", "busy low at done", int'(busy_o), 0);
        chk(nbits - bits0 == 9 * words, "R5", "bit count", nbits - bits0, 9 * words);
        chk(cs_falls - falls0 == 1, "R7", "cs assertions", cs_falls - falls0, 1);
        e = exp_bits(a, npe, v);
        mask = (1 << (9 * words)) - 1;
        chk((int'(cap) & mask) == int'(e), interfere ? "R9" : (npe == 0 ? "R3" : "R6"),
            "serial words", int'(cap) & mask, int'(e));
        @(posedge clk);
        @(negedge clk);
        chk(done_o === 1'b0, "R8", "done one cycle", int'(done_o), 0);
    endtask

    task automatic t_reset();
        chk(cs_n_o === 1'b1 && sclk_o === 1'b1 && mosi_o === 1'b1, "R1",
            "pins idle", {29'd0, cs_n_o, sclk_o, mosi_o}, 7);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R1", "flags idle",
            {30'd0, busy_o, done_o}, 0);
    endtask

    task automatic t_cmd_only();      // R3
        run_tx(8'hA5, 2'd0, 16'h0000, 1'b0);
        run_tx(8'h3C, 2'd0, 16'hFFFF, 1'b0);
    endtask

    task automatic t_one_byte();      // R4 R6
        run_tx(8'h5E, 2'd1, 16'hE74B, 1'b0);
    endtask

    task automatic t_two_bytes();     // R4 R6
        run_tx(8'hC1, 2'd2, 16'h9D26, 1'b0);
    endtask

    task automatic t_clamp();         // R5: nparm 3 acts as 2
        run_tx(8'h07, 2'd3, 16'h1B80, 1'b0);
    endtask

    task automatic t_busy_ignore();   // R9
        run_tx(8'h6A, 2'd1, 16'h00D3, 1'b1);
    endtask

    task automatic t_back_to_back();  // R10
        int held;
        run_tx(8'h81, 2'd0, 16'h0000, 1'b0);
        // issue the next request in the cycle done is seen
        @(negedge clk);
        req_i = 1'b1; addr_i = 8'h42; nparm_i = 2'd1; value_i = 16'h0011;
        while (done_o !== 1'b1) begin
            @(posedge clk);
            @(negedge clk);
            req_i = 1'b0;
        end
        req_i = 1'b1; addr_i = 8'h99; nparm_i = 2'd0; value_i = 16'h0;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
        chk(busy_o === 1'b1, "R10", "accepted in done cycle", int'(busy_o), 1);
        repeat (HALF + 2) @(negedge clk);
        held = last_gap;
        chk(held == 2 * HALF + 1, "R10", "cs high gap", held, 2 * HALF + 1);
        while (done_o !== 1'b1) @(negedge clk);
        chk((int'(cap) & 32'h1FF) == 32'h099, "R3", "second command", int'(cap) & 32'h1FF, 32'h099);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=expired expected=finished");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_only();
        t_one_byte();
        t_two_bytes();
        t_clamp();
        t_busy_ignore();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule